// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Hub

This block keeps two pending-interrupt vectors for a small multiprocessor: one bit per CPU for interprocessor interrupts (IPIs) and one bit per CPU for interval-timer interrupts. Each bit drives a dedicated interrupt line to its CPU. Software controls both vectors through one 64-bit command word. The word holds three independent 4-bit masks. One posts IPIs, one acknowledges IPIs and one acknowledges timer interrupts. A single-cycle tick input raises a timer interrupt on every present CPU.

A read of the same word returns both pending vectors and the number of the CPU that issued the read. Three sticky status lines report misuse. The first flags a post to a CPU whose IPI is already pending. The second flags an acknowledge with nothing to acknowledge. The third flags a non-zero mask that names no present CPU. A read returns these flags to zero. The number of CPUs present is a parameter from one to four.

Top module: `cpu_irq_hub`

## Requirements
- R1: Reset clears both pending vectors, all eight interrupt outputs and all three status flags.
- R2: A write with bit 12+n of `wr_data` set marks CPU n's IPI pending. `ipi_irq[n]` rises in the cycle after the write.
- R3: A write with bit 8+n set clears CPU n's IPI pending. When the same write also posts to CPU n, the clear wins.
- R4: Posting to a CPU whose IPI is already pending leaves its state unchanged and sets `warn_dup`.
- R5: Acknowledging an IPI for a CPU with none pending (and no post in the same write) changes nothing and sets `warn_nopend`.
- R6: A cycle with `tick` high sets the timer-pending bit of every present CPU. A timer acknowledge in the same cycle does not cancel the tick.
- R7: A write with bit 4+n set clears CPU n's timer-pending bit. A clear where nothing is pending is silently ignored.
- R8: `rd_data` returns `rd_cpu` in bits [1:0], the timer-pending vector in bits [7:4] and the IPI-pending vector in bits [11:8]. All other bits read as zero.
- R9: A write in which any of the three masks is non-zero but selects no present CPU sets `err_mask`. All-zero masks, and bits outside [15:4], never do.
- R10: Mask bits for CPUs at or above `NUM_CPU` are ignored. They raise no interrupt and no warning, and the outputs for those slots stay low.
- R11: The status flags hold until a cycle with `rd_en` high and are clear after it. An event in the same cycle as the read keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 64 | Command word (post [15:12], IPI ack [11:8], timer ack [7:4]) |
| rd_en | input | 1 | Read strobe; clears the status flags |
| rd_cpu | input | 2 | Number of the CPU issuing the read |
| rd_data | output | 64 | Pending vectors and requester number |
| tick | input | 1 | Periodic timer pulse |
| ipi_irq | output | 4 | Per-CPU interprocessor interrupt lines |
| tmr_irq | output | 4 | Per-CPU timer interrupt lines |
| warn_dup | output | 1 | Sticky: post to an already pending CPU |
| warn_nopend | output | 1 | Sticky: IPI acknowledge with nothing pending |
| err_mask | output | 1 | Sticky: non-zero mask naming no present CPU |

## Verification
The bench uses three CPUs, so one slot is absent. The command masks are tried in several forms:
- Disjoint posts, which show that each lane is independent.
- Overlapping posts, which separate a fresh post from a duplicate.
- A post and an acknowledge of one CPU in the same word, which fixes their priority.
- Masks that touch only the absent slot, which separate an ignored bit from an error.
- Words with every bit outside the fields set, which show the decode ignores them.

A tick alone and a tick together with a timer acknowledge pin the timer priority. Reads issued during events show that a new flag set takes priority over a read clear.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
   localparam int SLOTS     = 4;
   localparam int ID_W      = $clog2(SLOTS);
   localparam int POST_LSB  = 12;
   localparam int IACK_LSB  = 8;
   localparam int TACK_LSB  = 4;
   localparam int RD_ID_LSB = 0;
   localparam int RD_T_LSB  = 4;
   localparam int RD_I_LSB  = 8;

   typedef logic [SLOTS-1:0] cpu_vec_t;

   typedef struct packed {
      cpu_vec_t post;
      cpu_vec_t iack;
      cpu_vec_t tack;
   } cmd_t;

   function automatic cpu_vec_t present_mask(input int n);
      cpu_vec_t m;
      for (int i = 0; i < SLOTS; i++) m[i] = (i < n);
      return m;
   endfunction
endpackage

// File: rtl/ipt_cmd_decode.sv
module ipt_cmd_decode
   import ipt_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 64
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output cmd_t              cmd,
   output logic              no_target
);
   localparam cpu_vec_t PRES = present_mask(NUM_CPU);

   cpu_vec_t raw_post, raw_iack, raw_tack;
   logic     unused_bits;

   assign raw_post = wr_data[POST_LSB +: SLOTS];
   assign raw_iack = wr_data[IACK_LSB +: SLOTS];
   assign raw_tack = wr_data[TACK_LSB +: SLOTS];
   assign unused_bits = ^{wr_data[DATA_W-1:POST_LSB+SLOTS], wr_data[TACK_LSB-1:0]};

   always_comb begin
      cmd.post = wr_en ? (raw_post & PRES) : '0;
      cmd.iack = wr_en ? (raw_iack & PRES) : '0;
      cmd.tack = wr_en ? (raw_tack & PRES) : '0;
      no_target = wr_en &&
                  (((raw_post != '0) && ((raw_post & PRES) == '0)) ||
                   ((raw_iack != '0) && ((raw_iack & PRES) == '0)) ||
                   ((raw_tack != '0) && ((raw_tack & PRES) == '0)));
   end
endmodule

// File: rtl/ipt_pend_bank.sv
module ipt_pend_bank #(
   parameter int W        = 4,
   parameter bit SET_WINS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] pend
);
   for (genvar i = 0; i < W; i++) begin : g_lane
      logic nxt;
      if (SET_WINS) begin : g_set_first
         assign nxt = set[i] | (pend[i] & ~clr[i]);
      end else begin : g_clr_first
         assign nxt = ~clr[i] & (set[i] | pend[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[i] <= 1'b0;
         else        pend[i] <= nxt;
      end
   end
endmodule

// File: rtl/ipt_sticky.sv
module ipt_sticky #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         clr,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= set | (clr ? '0 : q);
   end
endmodule

// File: rtl/cpu_irq_hub.sv
module cpu_irq_hub
   import ipt_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [1:0]        rd_cpu,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tick,
   output logic [3:0]        ipi_irq,
   output logic [3:0]        tmr_irq,
   output logic              warn_dup,
   output logic              warn_nopend,
   output logic              err_mask
);
   localparam cpu_vec_t PRES = present_mask(NUM_CPU);

   if (NUM_CPU < 1 || NUM_CPU > SLOTS) begin : g_bad_cpu
      $error("NUM_CPU out of range");
   end
   if (DATA_W < POST_LSB + SLOTS) begin : g_bad_w
      $error("DATA_W too narrow for command fields");
   end
   if (ID_W != 2) begin : g_bad_id
      $error("requester id field must be 2 bits");
   end

   cmd_t     cmd;
   logic     no_target;
   cpu_vec_t ipi_pend, tmr_pend;
   cpu_vec_t dup_hit, nop_hit;
   logic [2:0] flag_set, flag_q;

   ipt_cmd_decode #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_dec (
      .wr_en(wr_en), .wr_data(wr_data), .cmd(cmd), .no_target(no_target)
   );

   ipt_pend_bank #(.W(SLOTS), .SET_WINS(1'b0)) u_ipi (
      .clk(clk), .rst_n(rst_n), .set(cmd.post), .clr(cmd.iack), .pend(ipi_pend)
   );

   ipt_pend_bank #(.W(SLOTS), .SET_WINS(1'b1)) u_tmr (
      .clk(clk), .rst_n(rst_n), .set(tick ? PRES : '0), .clr(cmd.tack), .pend(tmr_pend)
   );

   assign dup_hit  = cmd.post & ipi_pend;
   assign nop_hit  = cmd.iack & ~(ipi_pend | cmd.post);
   assign flag_set = {no_target, |nop_hit, |dup_hit};

   ipt_sticky #(.W(3)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(rd_en), .q(flag_q)
   );

   assign warn_dup    = flag_q[0];
   assign warn_nopend = flag_q[1];
   assign err_mask    = flag_q[2];
   assign ipi_irq     = ipi_pend;
   assign tmr_irq     = tmr_pend;

   always_comb begin
      rd_data = '0;
      rd_data[RD_ID_LSB +: ID_W] = rd_cpu;
      rd_data[RD_T_LSB +: SLOTS] = tmr_pend;
      rd_data[RD_I_LSB +: SLOTS] = ipi_pend;
   end
endmodule

// File: rtl/cpu_irq_hub_chk.sv
module cpu_irq_hub_chk
   import ipt_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic              tick,
   input logic [3:0]        ipi_irq,
   input logic [3:0]        tmr_irq,
   input logic              warn_dup,
   input logic              warn_nopend,
   input logic              err_mask
);
   localparam logic [3:0] PRES = present_mask(NUM_CPU);

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (ipi_irq == 4'h0 && tmr_irq == 4'h0 && !warn_dup && !warn_nopend && !err_mask));

   a_r2_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((ipi_irq & $past(wr_data[15:12] & ~wr_data[11:8] & PRES))
                 == $past(wr_data[15:12] & ~wr_data[11:8] & PRES)));

   a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((ipi_irq & $past(wr_data[11:8])) == 4'h0));

   a_r3_ipi_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ipi_irq));

   a_r4_dup_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((wr_data[15:12] & ipi_irq & PRES) != 4'h0)) |=> warn_dup);

   a_r6_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((tmr_irq & PRES) == PRES));

   a_r9_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[15:12] != 4'h0 && (wr_data[15:12] & PRES) == 4'h0) |=> err_mask);

   a_r10_absent_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((ipi_irq | tmr_irq) & ~PRES) == 4'h0);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && (warn_dup || warn_nopend || err_mask))
      |=> ((warn_dup || !$past(warn_dup)) && (warn_nopend || !$past(warn_nopend))
           && (err_mask || !$past(err_mask))));

   a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> (!warn_dup && !warn_nopend && !err_mask));
endmodule

bind cpu_irq_hub cpu_irq_hub_chk #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
   .tick(tick), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .warn_dup(warn_dup),
   .warn_nopend(warn_nopend), .err_mask(err_mask)
);

// File: tb/tb_cpu_irq_hub.sv
module tb_cpu_irq_hub;
   localparam int CLK_PERIOD = 10;
   localparam int NCPU = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_cpu = '0;
   logic [63:0] rd_data;
   logic        tick = 1'b0;
   logic [3:0]  ipi_irq, tmr_irq;
   logic        warn_dup, warn_nopend, err_mask;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_irq_hub #(.NUM_CPU(NCPU), .DATA_W(64)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_cpu(rd_cpu), .rd_data(rd_data), .tick(tick), .ipi_irq(ipi_irq),
      .tmr_irq(tmr_irq), .warn_dup(warn_dup), .warn_nopend(warn_nopend), .err_mask(err_mask)
   );

   function automatic logic [63:0] cmd(input logic [3:0] post, input logic [3:0] iack,
                                       input logic [3:0] tack);
      return {48'h0, post, iack, tack, 4'h0};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input logic [3:0] ei, input logic [3:0] et,
                            input logic [2:0] ef);
      chk({req, " ipi"}, {60'h0, ipi_irq}, {60'h0, ei});
      chk({req, " tmr"}, {60'h0, tmr_irq}, {60'h0, et});
      chk({req, " flags"}, {61'h0, err_mask, warn_nopend, warn_dup}, {61'h0, ef});
   endtask

   task automatic do_write(input logic [63:0] d, input bit tk = 1'b0);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; tick = tk;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; tick = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] id, input logic [63:0] exp, input string req);
      @(negedge clk);
      rd_en = 1'b1; rd_cpu = id;
      #1 chk(req, rd_data, exp);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset;
      chk_state("R1", 4'h0, 4'h0, 3'b000);
      @(negedge clk); rd_cpu = 2'd2; #1;
      chk("R1 R8 read after reset", rd_data, 64'h2);
   endtask

   task automatic t_post;
      do_write(cmd(4'b0101, 4'h0, 4'h0));
      chk_state("R2 post", 4'b0101, 4'h0, 3'b000);
   endtask

   task automatic t_dup;
      do_write(cmd(4'b0011, 4'h0, 4'h0));
      chk_state("R4 dup", 4'b0111, 4'h0, 3'b001);
      do_read(2'd1, 64'h701, "R8 layout");
      chk_state("R11 read clears", 4'b0111, 4'h0, 3'b000);
   endtask

   task automatic t_clear;
      do_write(cmd(4'h0, 4'b0011, 4'h0));
      chk_state("R3 ack", 4'b0100, 4'h0, 3'b000);
      do_write(cmd(4'h0, 4'b0010, 4'h0));
      chk_state("R5 nopend", 4'b0100, 4'h0, 3'b010);
      do_read(2'd0, 64'h400, "R8 after nopend");
      do_write(cmd(4'b0010, 4'b0010, 4'h0));
      chk_state("R3 ack wins over post", 4'b0100, 4'h0, 3'b000);
   endtask

   task automatic t_absent;
      do_write(cmd(4'b1000, 4'h0, 4'h0));
      chk_state("R9 R10 absent only", 4'b0100, 4'h0, 3'b100);
      do_read(2'd0, 64'h400, "R8 absent read");
      do_write(cmd(4'b1010, 4'h0, 4'h0));
      chk_state("R10 mixed mask", 4'b0110, 4'h0, 3'b000);
      do_write(64'hFFFF_FFFF_FFFF_000F);
      chk_state("R9 outside bits", 4'b0110, 4'h0, 3'b000);
   endtask

   task automatic t_timer;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk_state("R6 tick", 4'b0110, 4'b0111, 3'b000);
      do_read(2'd3, 64'h673, "R8 with timer");
      do_write(cmd(4'h0, 4'h0, 4'b0001));
      chk_state("R7 tack", 4'b0110, 4'b0110, 3'b000);
      do_write(cmd(4'h0, 4'h0, 4'b0001));
      chk_state("R7 tack idle", 4'b0110, 4'b0110, 3'b000);
      do_write(cmd(4'h0, 4'h0, 4'b1000));
      chk_state("R9 tack absent", 4'b0110, 4'b0110, 3'b100);
      do_read(2'd0, 64'h660, "R8 read");
      do_write(cmd(4'h0, 4'h0, 4'b0110), 1'b1);
      chk_state("R6 tick wins", 4'b0110, 4'b0111, 3'b000);
   endtask

   task automatic t_sticky;
      do_write(cmd(4'b0010, 4'h0, 4'h0));
      repeat (3) @(negedge clk);
      chk_state("R11 hold", 4'b0110, 4'b0111, 3'b001);
      @(negedge clk);
      wr_en = 1'b1; wr_data = cmd(4'b0100, 4'h0, 4'h0); rd_en = 1'b1; rd_cpu = 2'd0;
      #1 chk("R8 during event", rd_data, 64'h670);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
      chk_state("R11 set beats read", 4'b0110, 4'b0111, 3'b001);
      do_read(2'd0, 64'h670, "R8 final");
      chk_state("R11 cleared", 4'b0110, 4'b0111, 3'b000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_post();
      t_dup();
      t_clear();
      t_absent();
      t_timer();
      t_sticky();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule